// File: doc/BRIEF.md
# Data Bus Tenure Handshake Controller

This block decides which of several local bus masters owns the data bus of a shared split-transaction bus, and runs that master's side of the tenure handshake. Each master offers a data transaction on a valid/ready request channel that carries a priority and a burst flag. When the data bus is free, the arbiter issues a one-cycle grant to the best pending request. The master's tenure agent takes mastership only if the grant is still qualified at the clock edge: no outside device may be asserting the shared busy line. The agent then drives the active-high busy line with its own output enable, counts transfer acknowledges, ends the tenure early on a transfer error or a retry, drives busy inactive for one cycle and then releases the line to high impedance.

Back-pressure rules for the request channel: a master raises `req_valid_i` and holds it, together with its priority and burst fields, until it sees `req_ready_o` high in a cycle. A cycle with valid and ready both high is the acceptance, and the tenure starts at that clock edge. Ready is high only in a cycle where the master's grant is high and the outside busy line is low. A master that drops valid before acceptance withdraws its request, and a grant it receives after that is ignored. The acknowledge, error and retry inputs are plain shared bus strobes and apply to whichever master currently holds the tenure.

Top module: `dbt_tenure_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, every grant, ready, busy and enable output is low.
- R2: Suppose a cycle has at least one valid request, a low outside busy line, no enable of this block high and no grant high. The next cycle then raises exactly one grant bit, for the winning requester.
- R3: The winner has the numerically largest 2-bit priority field among valid requesters (requester i's field is bits [2i+1:2i] of `req_prio_i`, 3 is highest). Equal priorities go to the lowest index.
- R4: Every grant bit is high for exactly one cycle.
- R5: A grant is never issued in the cycle after one where the outside busy line or any of this block's enables was high. This includes the hold cycle at the end of a tenure.
- R6: A grant is qualified when its cycle has the outside busy line low and the request still valid. The master's ready is then high in that cycle, and its busy and enable outputs are high in the next cycle. An unqualified grant starts no tenure, and the still-valid request is granted again once the bus is free.
- R7: A tenure ends after 1 acknowledge when the burst flag sampled at acceptance was 0, and after 4 acknowledges when it was 1. Busy is low in the cycle after the final acknowledge.
- R8: A transfer error or a retry during a tenure ends it, and busy is low in the next cycle whatever the acknowledge count.
- R9: When busy falls, the enable stays high with busy low for exactly one cycle, then drops.
- R10: At most one enable output is high in any cycle.
- R11: Acknowledge, error and retry strobes that arrive while no tenure is active change no output and are not counted toward a later tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | N | Per-master request valid |
| req_prio_i | input | N*PW | Per-master priority fields, master i at [PW*i +: PW] |
| req_burst_i | input | N | Per-master burst flag (1 = multi-beat tenure) |
| req_ready_o | output | N | Per-master acceptance, high while grant is qualified |
| grant_o | output | N | One-cycle data bus grant per master |
| ext_busy_i | input | 1 | Busy line as driven by devices outside this block |
| busy_o | output | N | Per-master busy drive value |
| busy_oe_o | output | N | Per-master output enable for the busy line |
| xfer_ack_i | input | 1 | Transfer acknowledge strobe |
| xfer_err_i | input | 1 | Transfer error strobe |
| xfer_retry_i | input | 1 | Retry strobe that ends the tenure |

## Verification
The bound checker watches, on every cycle, the grant's shape and timing: at most one bit set, one cycle wide, and only after a cycle with the bus free. It also checks that an acceptance turns into busy plus enable on the next cycle, that an error or retry drops busy at once, that the enable outlives busy by exactly one hold cycle, and that a single master drives the line. Only the bench's scenarios can show which requester wins for a given set of priorities and ties, and that the beat count depends on the burst flag captured at acceptance. The same goes for re-granting after a grant lost to the outside busy line, and for stray strobes between tenures leaving the next one's count unchanged.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    TN_IDLE = 2'd0,
    TN_OWN  = 2'd1,
    TN_HOLD = 2'd2
  } tn_state_e;
endpackage

// File: rtl/dbt_arbiter.sv
module dbt_arbiter #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]    valid,
  input  logic [N*PW-1:0] prio,
  input  logic          bus_free,
  output logic [N-1:0]    gnt
);
  logic [N-1:0] pick;

  // Highest priority wins; strict compare keeps the lowest index on ties.
  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (!found || prio[i*PW +: PW] > best)) begin
        found   = 1'b1;
        best    = prio[i*PW +: PW];
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gnt <= '0;
    else if (bus_free && gnt == '0) gnt <= pick;
    else gnt <= '0;
  end
endmodule

// File: rtl/dbt_agent.sv
module dbt_agent #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic valid,
  input  logic burst,
  input  logic ext_busy,
  input  logic ack,
  input  logic err,
  input  logic retry,
  output logic ready,
  output logic busy,
  output logic busy_oe
);
  import dbt_pkg::*;

  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  tn_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          burst_q;
  logic          last_beat;

  assign ready     = gnt & valid & ~ext_busy;
  assign last_beat = ~burst_q | (cnt_q == CW'(BEATS - 1));
  assign busy      = (state_q == TN_OWN);
  assign busy_oe   = (state_q != TN_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TN_IDLE;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      unique case (state_q)
        TN_IDLE: begin
          if (ready) begin
            state_q <= TN_OWN;
            burst_q <= burst;
            cnt_q   <= '0;
          end
        end
        TN_OWN: begin
          if (err || retry) state_q <= TN_HOLD;
          else if (ack) begin
            if (last_beat) state_q <= TN_HOLD;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        TN_HOLD: state_q <= TN_IDLE;
        default: state_q <= TN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbt_tenure_ctrl.sv
module dbt_tenure_ctrl #(
  parameter int N     = 4,
  parameter int PW    = 2,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]    req_valid_i,
  input  logic [N*PW-1:0] req_prio_i,
  input  logic [N-1:0]    req_burst_i,
  output logic [N-1:0]    req_ready_o,
  output logic [N-1:0]    grant_o,
  input  logic          ext_busy_i,
  output logic [N-1:0]    busy_o,
  output logic [N-1:0]    busy_oe_o,
  input  logic          xfer_ack_i,
  input  logic          xfer_err_i,
  input  logic          xfer_retry_i
);
  logic bus_free;

  assign bus_free = ~ext_busy_i & ~(|busy_oe_o);

  dbt_arbiter #(.N(N), .PW(PW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (req_valid_i),
    .prio     (req_prio_i),
    .bus_free (bus_free),
    .gnt      (grant_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_agent
    dbt_agent #(.BEATS(BEATS)) u_agent (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt      (grant_o[g]),
      .valid    (req_valid_i[g]),
      .burst    (req_burst_i[g]),
      .ext_busy (ext_busy_i),
      .ack      (xfer_ack_i),
      .err      (xfer_err_i),
      .retry    (xfer_retry_i),
      .ready    (req_ready_o[g]),
      .busy     (busy_o[g]),
      .busy_oe  (busy_oe_o[g])
    );
  end
endmodule

// File: rtl/dbt_tenure_chk.sv
module dbt_tenure_chk #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]    req_ready_o,
  input logic [N-1:0]    grant_o,
  input logic          ext_busy_i,
  input logic [N-1:0]    busy_o,
  input logic [N-1:0]    busy_oe_o,
  input logic          xfer_err_i,
  input logic          xfer_retry_i
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2

  AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |=> (grant_o == '0)); // R4

  AST_GNT_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> $past(!ext_busy_i && busy_oe_o == '0)); // R5

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready_o) |=> ((busy_o & busy_oe_o) == $past(req_ready_o))); // R6

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_err_i || xfer_retry_i) && (|busy_o)) |=> (busy_o == '0)); // R8

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_oe_o)); // R10

  AST_BUSY_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_o & ~busy_oe_o) == '0)); // R9

  for (genvar g = 0; g < N; g++) begin : g_hold
    AST_HOLD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o[g]) |-> busy_oe_o[g]); // R9
    AST_HOLD_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_oe_o[g] && !busy_o[g]) |=> !busy_oe_o[g]); // R9
  end
endmodule

bind dbt_tenure_ctrl dbt_tenure_chk #(.N(N), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready_o  (req_ready_o),
  .grant_o      (grant_o),
  .ext_busy_i   (ext_busy_i),
  .busy_o       (busy_o),
  .busy_oe_o    (busy_oe_o),
  .xfer_err_i   (xfer_err_i),
  .xfer_retry_i (xfer_retry_i)
);

// File: tb/dbt_tenure_ctrl_bench.sv
module dbt_tenure_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int BEATS = 4;

  // {valid[3:0], prio{p3,p2,p1,p0}[7:0], burst[3:0], expected winner[1:0]}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {4'b0001, 8'b00_00_00_00, 4'b0000, 2'd0},
    {4'b1111, 8'b11_10_11_01, 4'b0010, 2'd1},
    {4'b1100, 8'b10_10_00_00, 4'b0000, 2'd2},
    {4'b1010, 8'b01_00_00_00, 4'b1000, 2'd3},
    {4'b0110, 8'b00_11_11_00, 4'b0000, 2'd1},
    {4'b1001, 8'b01_00_00_10, 4'b0001, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*PW-1:0] req_prio = '0;
  logic [N-1:0]    req_burst = '0;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    grant;
  logic          ext_busy = 1'b0;
  logic [N-1:0]    busy;
  logic [N-1:0]    busy_oe;
  logic          ack = 1'b0;
  logic          err = 1'b0;
  logic          retry = 1'b0;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbt_tenure_ctrl #(.N(N), .PW(PW), .BEATS(BEATS)) u_dbt_tenure_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_prio_i   (req_prio),
    .req_burst_i  (req_burst),
    .req_ready_o  (req_ready),
    .grant_o      (grant),
    .ext_busy_i   (ext_busy),
    .busy_o       (busy),
    .busy_oe_o    (busy_oe),
    .xfer_ack_i   (ack),
    .xfer_err_i   (err),
    .xfer_retry_i (retry)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge with the bus free; leaves the tenure running.
  task automatic start_req(input logic [3:0] vld, input logic [7:0] pr,
                           input logic [3:0] bu, input int exp);
    logic [3:0] oh;
    oh = 4'(1 << exp);
    req_valid = vld; req_prio = pr; req_burst = bu;
    @(negedge clk);
    check("R2/R3 grant to winner", grant, oh);
    check("R6 ready with qualified grant", req_ready, oh);
    @(negedge clk);
    req_valid = '0;
    check("R4 grant one cycle", grant, 0);
    check("R6 busy after acceptance", busy, oh);
    check("R6 enable after acceptance", busy_oe, oh);
  endtask

  task automatic finish_beats(input int exp, input int beats);
    logic [3:0] oh;
    oh = 4'(1 << exp);
    for (int k = 0; k < beats; k++) begin
      if (k > 0) check("R7 busy before final ack", busy, oh);
      ack = 1'b1;
      @(negedge clk);
    end
    ack = 1'b0;
    check("R7 busy low after final ack", busy, 0);
    check("R9 enable held in hold cycle", busy_oe, oh);
    @(negedge clk);
    check("R9 enable released", busy_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    req_valid = 4'b0001;
    repeat (3) @(negedge clk);
    check("R1 grant in reset", grant, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 enable in reset", busy_oe, 0);
    rst_n = 1'b1;
    req_valid = '0;
    @(negedge clk);
    check("R1 grant after reset", grant, 0);
    check("R1 ready after reset", req_ready, 0);

    // Vector table walk: R2, R3, R6, R7, R9
    for (int v = 0; v < NV; v++) begin
      logic [17:0] e;
      e = VEC[v];
      start_req(e[17:14], e[13:6], e[5:2], int'(e[1:0]));
      finish_beats(int'(e[1:0]), e[2 + e[1:0]] ? BEATS : 1);
      @(negedge clk);
    end

    // R11: stray strobes with no tenure, then a burst still needs all beats
    ack = 1'b1; @(negedge clk);
    ack = 1'b1; err = 1'b1; @(negedge clk);
    ack = 1'b0; err = 1'b0; retry = 1'b1; @(negedge clk);
    retry = 1'b0;
    check("R11 no busy from stray strobes", busy, 0);
    check("R11 no enable from stray strobes", busy_oe, 0);
    check("R11 no grant from stray strobes", grant, 0);
    @(negedge clk);
    start_req(4'b0001, 8'h00, 4'b0001, 0);
    finish_beats(0, BEATS); // R11 stray acks not counted
    @(negedge clk);

    // R8: error after one beat of a burst
    start_req(4'b0100, 8'h00, 4'b0100, 2);
    ack = 1'b1; @(negedge clk);
    ack = 1'b0; err = 1'b1; @(negedge clk);
    err = 1'b0;
    check("R8 error ends tenure", busy, 0);
    check("R9 enable held after error", busy_oe, 4'b0100);
    @(negedge clk);
    check("R9 enable released after error", busy_oe, 0);

    // R8: retry ends a single-beat tenure
    start_req(4'b0001, 8'h00, 4'b0000, 0);
    retry = 1'b1; @(negedge clk);
    retry = 1'b0;
    check("R8 retry ends tenure", busy, 0);
    @(negedge clk);
    check("R9 enable released after retry", busy_oe, 0);

    // R5/R6: outside busy blocks grants and disqualifies one
    ext_busy = 1'b1;
    req_valid = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 no grant while outside busy", grant, 0);
    end
    ext_busy = 1'b0;
    @(negedge clk);
    check("R2 grant once bus frees", grant, 4'b0010);
    ext_busy = 1'b1;
    #1;
    check("R6 ready low when grant unqualified", req_ready, 0);
    @(negedge clk);
    check("R6 unqualified grant starts nothing", busy, 0);
    check("R4 grant dropped", grant, 0);
    ext_busy = 1'b0;
    @(negedge clk);
    check("R6 pending request granted again", grant, 4'b0010);
    @(negedge clk);
    req_valid = '0;
    check("R6 busy after re-grant", busy, 4'b0010);
    finish_beats(1, 1);
    @(negedge clk);

    // R5: hold cycle blocks the next grant
    req_valid = 4'b0011; req_prio = '0; req_burst = '0;
    @(negedge clk);
    check("R3 tie to lowest index", grant, 4'b0001);
    @(negedge clk);
    req_valid = 4'b0010;
    check("R6 first master owns bus", busy, 4'b0001);
    ack = 1'b1; @(negedge clk);
    ack = 1'b0;
    check("R5 no grant during hold", grant, 0);
    check("R9 hold enable", busy_oe, 4'b0001);
    @(negedge clk);
    check("R5 no grant in release cycle", grant, 0);
    check("R9 enable dropped", busy_oe, 0);
    @(negedge clk);
    check("R2 next requester granted", grant, 4'b0010);
    @(negedge clk);
    req_valid = '0;
    check("R6 second master owns bus", busy, 4'b0010);
    finish_beats(1, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule